// File: doc/BRIEF.md
# Render Buffer Tag Allocator

A small tag table that decides which of a handful of off-chip render buffers a new render or scan-out frame should use. Each entry remembers the buffer's base address (with a flag saying whether that address is still meaningful), its width and height, its byte size, whether the entry exists at all, and whether its contents have already been written back to memory. The buffer storage and the copy engine that performs write-backs live elsewhere; this block only chooses and reports.

An allocate request presents an address, a width, a height and a byte size. In a single cycle the table is scanned from the lowest index. It reuses an exact match, then a same-sized entry whose address has been dropped, then a never-used slot, and only then evicts. The two field addresses currently being scanned out and the entry index currently on screen are never evicted. The result is registered and appears one cycle later. That result is the chosen index, whether that buffer must be written back first, whether it is a fresh slot, and a mask of other entries that must be written back because the request made their address stale.

An invalidate probe presents a 32-bit address from a memory access. The table reports which live entry's byte range covers it and whether a write-back is needed. A write probe also drops that entry's address.

Top module: `render_tag_alloc`

## Requirements
- R1: After reset the table holds no entries, `alloc_done` and `inv_done` are 0, and any probe reports `inv_hit`=0.
- R2: An entry with the requested width, height and valid address that is not the displayed index (`disp_vld`=1 and `disp_idx`=entry) is chosen first, with `alloc_flush`=0 and `alloc_new`=0; among several, the lowest index wins.
- R3: An exact match that is the displayed index is not chosen, and its address becomes invalid, so a later probe inside its old range does not report it.
- R4: With no usable exact match, the lowest entry with equal width and height, an invalid address, and not the displayed index is chosen, with `alloc_flush`=0 and `alloc_new`=0.
- R5: A live entry with the requested address but different width or height has its address invalidated; its bit in `side_flush` (bit i for entry i) is 1 only when its width×height exceeds the request's.
- R6: With nothing reusable and fewer than NENT entries live, the next unused index (equal to the number of live entries) is taken, with `alloc_new`=1 and `alloc_flush`=0.
- R7: With nothing reusable and the table full, the lowest entry is evicted whose valid address equals neither `disp_field0` nor `disp_field1` and which is not the displayed index; `alloc_flush` is 1 exactly when that entry was not yet written back, and `alloc_ok`=0 if no entry qualifies.
- R8: A successful allocate loads the chosen entry with the request's address, width, height and size, marks the address valid and marks it not written back.
- R9: A probe uses only the low 29 bits of `inv_addr` and hits the lowest live entry with a valid address whose range [address, address+size) contains it; `inv_flush` is 1 when that entry was not yet written back, the entry is then marked written back, and when `inv_write`=1 its address becomes invalid.
- R10: Results appear on the cycle after the request with `alloc_done` or `inv_done` high for one cycle; a probe presented together with an allocate is dropped and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocate request strobe |
| alloc_addr | input | 29 | Requested buffer base address |
| alloc_w | input | 11 | Requested width |
| alloc_h | input | 11 | Requested height |
| alloc_size | input | 24 | Requested buffer size in bytes |
| disp_field0 | input | 29 | First scan-out field address |
| disp_field1 | input | 29 | Second scan-out field address |
| disp_vld | input | 1 | An entry is currently on screen |
| disp_idx | input | 2 | Index of the entry on screen |
| inv_req | input | 1 | Invalidate probe strobe |
| inv_addr | input | 32 | Probe address (upper bits ignored) |
| inv_write | input | 1 | Probe comes from a write |
| alloc_done | output | 1 | Allocate result valid |
| alloc_ok | output | 1 | An entry was assigned |
| alloc_idx | output | 2 | Assigned entry index |
| alloc_flush | output | 1 | Assigned entry needs write-back first |
| alloc_new | output | 1 | Assigned entry was previously unused |
| side_flush | output | 4 | Other entries needing write-back before their address is dropped |
| inv_done | output | 1 | Probe result valid |
| inv_hit | output | 1 | Probe address falls in an entry |
| inv_idx | output | 2 | Entry that was hit |
| inv_flush | output | 1 | Hit entry needs write-back |

## Verification
The hardest state to reach is a full table in which eviction has to step past entries protected by each of the three different rules. The first field address protects one entry, the second field address another, and the on-screen index a third, all while one entry has just lost its address to a size mismatch. The stimulus gets there by filling the table through fresh slots, a displayed exact match and a spare reuse. It then shrinks a buffer at an existing address and moves the field addresses and on-screen index onto different entries. Write-back state for the victim is prepared with earlier probes, so that both values of the eviction flush are observed.

// File: rtl/render_tag_alloc.sv
module render_tag_alloc #(
  parameter int NENT = 4,
  parameter int AW   = 29,
  parameter int DW   = 11,
  parameter int SW   = 24,
  parameter int PW   = 32,
  localparam int IW  = $clog2(NENT),
  localparam int CW  = $clog2(NENT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_req,
  input  logic [AW-1:0]   alloc_addr,
  input  logic [DW-1:0]   alloc_w,
  input  logic [DW-1:0]   alloc_h,
  input  logic [SW-1:0]   alloc_size,
  input  logic [AW-1:0]   disp_field0,
  input  logic [AW-1:0]   disp_field1,
  input  logic            disp_vld,
  input  logic [IW-1:0]   disp_idx,
  input  logic            inv_req,
  input  logic [PW-1:0]   inv_addr,
  input  logic            inv_write,
  output logic            alloc_done,
  output logic            alloc_ok,
  output logic [IW-1:0]   alloc_idx,
  output logic            alloc_flush,
  output logic            alloc_new,
  output logic [NENT-1:0] side_flush,
  output logic            inv_done,
  output logic            inv_hit,
  output logic [IW-1:0]   inv_idx,
  output logic            inv_flush
);
  localparam int AR = 2 * DW;

  logic [AW-1:0]   e_addr [NENT];
  logic [DW-1:0]   e_w    [NENT];
  logic [DW-1:0]   e_h    [NENT];
  logic [SW-1:0]   e_size [NENT];
  logic [NENT-1:0] e_live, e_av, e_fl;
  logic [CW-1:0]   n_live;
  logic            inv_wr_q;

  function automatic logic [IW-1:0] first_one(input logic [NENT-1:0] v);
    first_one = '0;
    for (int i = NENT - 1; i >= 0; i--)
      if (v[i]) first_one = IW'(i);
  endfunction

  wire [AR-1:0] area_req = AR'(alloc_w) * AR'(alloc_h);
  wire [PW-1:0] probe    = inv_addr & {{(PW-AW){1'b0}}, {AW{1'b1}}};
  wire          full     = (n_live == CW'(NENT));

  logic [NENT-1:0] perfect, spare, kill, big, cand, hit;

  always_comb begin
    for (int i = 0; i < NENT; i++) begin
      logic dim_eq, adr_eq, on_scr, av_post;
      dim_eq  = (e_w[i] == alloc_w) && (e_h[i] == alloc_h);
      adr_eq  = e_av[i] && (e_addr[i] == alloc_addr);
      on_scr  = disp_vld && (disp_idx == IW'(i));
      perfect[i] = e_live[i] && dim_eq && adr_eq && !on_scr;
      spare[i]   = e_live[i] && dim_eq && !e_av[i] && !on_scr;
      kill[i]    = e_live[i] && adr_eq && (!dim_eq || on_scr);
      big[i]     = e_live[i] && adr_eq && !dim_eq &&
                   ((AR'(e_w[i]) * AR'(e_h[i])) > area_req);
      av_post    = e_av[i] && !kill[i];
      cand[i]    = e_live[i] && !on_scr &&
                   !(av_post && ((e_addr[i] == disp_field0) || (e_addr[i] == disp_field1)));
      hit[i]     = e_live[i] && e_av[i] &&
                   ((PW+1)'(e_addr[i]) <= (PW+1)'(probe)) &&
                   (((PW+1)'(e_addr[i]) + (PW+1)'(e_size[i])) > (PW+1)'(probe));
    end
  end

  logic            s_ok, s_flush, s_new;
  logic [IW-1:0]   s_idx;

  always_comb begin
    s_ok = 1'b1; s_flush = 1'b0; s_new = 1'b0; s_idx = '0;
    if (|perfect)      s_idx = first_one(perfect);
    else if (|spare)   s_idx = first_one(spare);
    else if (!full) begin
      s_idx = n_live[IW-1:0];
      s_new = 1'b1;
    end else if (|cand) begin
      s_idx   = first_one(cand);
      s_flush = !e_fl[s_idx];
    end else
      s_ok = 1'b0;
  end

  wire [IW-1:0] h_idx = first_one(hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        e_addr[i] <= '0;
        e_w[i]    <= '0;
        e_h[i]    <= '0;
        e_size[i] <= '0;
      end
      e_live <= '0; e_av <= '0; e_fl <= '0; n_live <= '0;
      alloc_done <= 1'b0; alloc_ok <= 1'b0; alloc_idx <= '0;
      alloc_flush <= 1'b0; alloc_new <= 1'b0; side_flush <= '0;
      inv_done <= 1'b0; inv_hit <= 1'b0; inv_idx <= '0;
      inv_flush <= 1'b0; inv_wr_q <= 1'b0;
    end else begin
      alloc_done <= alloc_req;
      inv_done   <= inv_req && !alloc_req;
      inv_wr_q   <= inv_write;
      if (alloc_req) begin
        e_av <= e_av & ~kill;
        alloc_ok    <= s_ok;
        alloc_idx   <= s_idx;
        alloc_flush <= s_flush;
        alloc_new   <= s_new;
        side_flush  <= big;
        if (s_ok) begin
          e_addr[s_idx] <= alloc_addr;
          e_w[s_idx]    <= alloc_w;
          e_h[s_idx]    <= alloc_h;
          e_size[s_idx] <= alloc_size;
          e_av[s_idx]   <= 1'b1;
          e_fl[s_idx]   <= 1'b0;
          e_live[s_idx] <= 1'b1;
          if (s_new) n_live <= n_live + CW'(1);
        end
      end else if (inv_req) begin
        inv_hit   <= |hit;
        inv_idx   <= h_idx;
        inv_flush <= (|hit) && !e_fl[h_idx];
        if (|hit) begin
          e_fl[h_idx] <= 1'b1;
          if (inv_write) e_av[h_idx] <= 1'b0;
        end
      end
    end
  end

  a_r10_alloc_latency: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> alloc_done && !inv_done);
  a_r10_probe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && !alloc_req) |=> inv_done);
  a_r6_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (n_live <= CW'(NENT)) && (n_live >= $past(n_live)));
  a_r8_entry_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_done && alloc_ok) |-> (e_live[alloc_idx] && e_av[alloc_idx] && !e_fl[alloc_idx]));
  a_r7_flush_needs_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_done && alloc_flush) |-> (alloc_ok && !alloc_new));
  a_r9_probe_marks_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_done && inv_hit) |-> e_fl[inv_idx]);
  a_r9_write_drops_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_done && inv_hit && inv_wr_q) |-> !e_av[inv_idx]);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!alloc_done && !inv_done));
endmodule

// File: tb/render_tag_alloc_test.sv
`timescale 1ns/1ps
module render_tag_alloc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_req = 1'b0;
  logic [28:0] alloc_addr = '0;
  logic [10:0] alloc_w = '0, alloc_h = '0;
  logic [23:0] alloc_size = '0;
  logic [28:0] disp_field0 = 29'h1F00000, disp_field1 = 29'h1F00000;
  logic        disp_vld = 1'b0;
  logic [1:0]  disp_idx = '0;
  logic        inv_req = 1'b0;
  logic [31:0] inv_addr = '0;
  logic        inv_write = 1'b0;
  logic        alloc_done, alloc_ok, alloc_flush, alloc_new;
  logic [1:0]  alloc_idx, inv_idx;
  logic [3:0]  side_flush;
  logic        inv_done, inv_hit, inv_flush;

  render_tag_alloc uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_addr(alloc_addr), .alloc_w(alloc_w),
    .alloc_h(alloc_h), .alloc_size(alloc_size),
    .disp_field0(disp_field0), .disp_field1(disp_field1),
    .disp_vld(disp_vld), .disp_idx(disp_idx),
    .inv_req(inv_req), .inv_addr(inv_addr), .inv_write(inv_write),
    .alloc_done(alloc_done), .alloc_ok(alloc_ok), .alloc_idx(alloc_idx),
    .alloc_flush(alloc_flush), .alloc_new(alloc_new), .side_flush(side_flush),
    .inv_done(inv_done), .inv_hit(inv_hit), .inv_idx(inv_idx), .inv_flush(inv_flush)
  );

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit        q_kind [$];
  bit [31:0] q_exp  [$];
  string     q_tag  [$];

  localparam logic [28:0] A = 29'h1000, B = 29'h2000, C = 29'h3000,
                          D = 29'h4000, E = 29'h5000;

  task automatic check_one(input bit kind, input bit [31:0] act);
    nchk++;
    if (q_kind.size() == 0) begin
      nerr++;
      $display("FAIL R10 unexpected result kind=%0d actual=%h expected=none", kind, act);
    end else begin
      bit        k = q_kind.pop_front();
      bit [31:0] e = q_exp.pop_front();
      string     t = q_tag.pop_front();
      if (k != kind || e != act) begin
        nerr++;
        $display("FAIL %s actual=%h expected=%h", t, act, e);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && alloc_done)
      check_one(1'b0, {23'd0, alloc_ok, alloc_idx, alloc_flush, alloc_new, side_flush});
    if (rst_n && inv_done)
      check_one(1'b1, {28'd0, inv_hit, (inv_hit ? inv_idx : 2'b00), inv_flush});
  end

  task automatic alloc_op(input logic [28:0] a, input logic [10:0] w, input logic [10:0] h,
                          input logic [23:0] sz, input logic eok, input logic [1:0] eidx,
                          input logic efl, input logic enew, input logic [3:0] emask,
                          input string tag);
    q_kind.push_back(1'b0);
    q_exp.push_back({23'd0, eok, eidx, efl, enew, emask});
    q_tag.push_back(tag);
    alloc_addr = a; alloc_w = w; alloc_h = h; alloc_size = sz; alloc_req = 1'b1;
    @(negedge clk);
    alloc_req = 1'b0;
  endtask

  task automatic inv_op(input logic [31:0] a, input logic wr, input logic ehit,
                        input logic [1:0] eidx, input logic efl, input string tag);
    q_kind.push_back(1'b1);
    q_exp.push_back({28'd0, ehit, eidx, efl});
    q_tag.push_back(tag);
    inv_addr = a; inv_write = wr; inv_req = 1'b1;
    @(negedge clk);
    inv_req = 1'b0; inv_write = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    nchk++;
    if (alloc_done !== 1'b0 || inv_done !== 1'b0) begin
      nerr++;
      $display("FAIL R1 reset outputs actual=%b%b expected=00", alloc_done, inv_done);
    end
    rst_n = 1'b1;
    @(negedge clk);
    inv_op({3'd0, A}, 1'b0, 1'b0, 2'd0, 1'b0, "R1 empty table probe");

    alloc_op(A, 11'd10, 11'd10, 24'h100, 1, 2'd0, 0, 1, 4'b0000, "R6 first fresh slot");
    alloc_op(B, 11'd10, 11'd10, 24'h100, 1, 2'd1, 0, 1, 4'b0000, "R6 second fresh slot");
    alloc_op(A, 11'd10, 11'd10, 24'h100, 1, 2'd0, 0, 0, 4'b0000, "R2 exact match reuse");

    disp_vld = 1'b1; disp_idx = 2'd0;
    alloc_op(A, 11'd10, 11'd10, 24'h100, 1, 2'd2, 0, 1, 4'b0000, "R3 displayed match skipped");
    inv_op({3'd0, A + 29'd5}, 1'b0, 1'b1, 2'd2, 1'b1, "R3 R8 old range now owned by new entry");
    inv_op({3'd0, A + 29'd5}, 1'b0, 1'b1, 2'd2, 1'b0, "R9 second probe already flushed");

    disp_vld = 1'b0;
    alloc_op(C, 11'd10, 11'd10, 24'h100, 1, 2'd0, 0, 0, 4'b0000, "R4 spare entry reuse");
    alloc_op(B, 11'd5, 11'd5, 24'h40, 1, 2'd3, 0, 1, 4'b0010, "R5 larger stale entry flushed");
    inv_op({3'd0, B + 29'd1}, 1'b0, 1'b1, 2'd3, 1'b1, "R5 stale entry dropped from range");

    disp_field0 = A; disp_field1 = B; disp_vld = 1'b1; disp_idx = 2'd1;
    alloc_op(C, 11'd20, 11'd20, 24'h400, 1, 2'd0, 1, 0, 4'b0000, "R5 R7 smaller stale no side flush, victim unflushed");

    disp_field0 = C; disp_field1 = A; disp_idx = 2'd1;
    alloc_op(E, 11'd7, 11'd7, 24'h31, 1, 2'd3, 0, 0, 4'b0000, "R7 victim skips protected, already flushed");

    disp_vld = 1'b0;
    alloc_op(D, 11'd10, 11'd10, 24'h100, 1, 2'd1, 0, 0, 4'b0000, "R4 spare after eviction");

    inv_op({3'd0, E + 29'h31}, 1'b0, 1'b0, 2'd0, 1'b0, "R9 range end exclusive");
    inv_op({3'b111, E + 29'h30}, 1'b1, 1'b1, 2'd3, 1'b1, "R9 high bits masked write hit");
    inv_op({3'd0, E}, 1'b0, 1'b0, 2'd0, 1'b0, "R9 write dropped address");

    q_kind.push_back(1'b0);
    q_exp.push_back({23'd0, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0000});
    q_tag.push_back("R10 R2 allocate wins over probe");
    alloc_addr = C; alloc_w = 11'd20; alloc_h = 11'd20; alloc_size = 24'h400;
    alloc_req = 1'b1; inv_addr = {3'd0, C + 29'd1}; inv_req = 1'b1;
    @(negedge clk);
    alloc_req = 1'b0; inv_req = 1'b0;
    nchk++;
    if (inv_done !== 1'b0) begin
      nerr++;
      $display("FAIL R10 probe with allocate actual=%b expected=0", inv_done);
    end
    inv_op({3'd0, C + 29'd1}, 1'b0, 1'b1, 2'd0, 1'b1, "R10 R8 dropped probe left entry unflushed");

    repeat (3) @(negedge clk);
    nchk++;
    if (q_kind.size() != 0) begin
      nerr++;
      $display("FAIL R10 missing results actual=%0d expected=0", q_kind.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(4 * 20000);
    nchk++; nerr++;
    $display("FAIL R10 watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule